// File: doc/BRIEF.md
# Calendar Alarm Comparator with Per-Field Enables

This block holds one alarm time in the same BCD field layout that the calendar counter uses: seconds, minutes, hours with a PM bit, weekday, day of month, month and year. Each field has its own enable bit. On every one-second tick the block compares the enabled alarm fields against the live counter values. When every enabled field matches, it sets a sticky alarm flag. Software can leave some fields out of the match, so one alarm value can mean "every minute at :30", "every day at 07:00 PM" or one exact date and time.

Software programs the alarm through a simple byte-wide register write port. Each field register sits at its own even offset. The year field has a separate enable register. A status register clears the flag, and a control register holds the alarm interrupt enable. The interrupt output is the flag gated by that enable.

Top module: `cal_alarm_top`

## Requirements
- R1: After reset the alarm flag and the interrupt are 0, every field enable is 0 and the interrupt enable is 0.
- R2: On a cycle with `sec_tick` high, if at least one field is enabled and every enabled field equals the live value, `alarm_flag` is 1 from the next clock edge on.
- R3: Without `sec_tick` no match sets the flag, even when the live time matches.
- R4: A field whose enable is 0 takes no part in the match. Its mismatch does not stop the flag.
- R5: An enabled field that differs from the live value stops the flag from being set on that tick.
- R6: When no field is enabled the flag is never set.
- R7: The hours field compares its PM indicator (bit 6) as well as the BCD hour (bits 5:0).
- R8: The seconds, minutes, hours, weekday, day and month alarm registers are at offsets 0x10, 0x12, 0x14, 0x16, 0x18 and 0x1A. Each one takes its value from bits 6:0 and its enable from bit 7. The year value is at 0x1C and uses all 8 bits. Writing 0x1C leaves the year enable unchanged. The year enable is bit 7 of offset 0x1E.
- R9: The flag stays set until a write of 0 to bit 0 of the status register at offset 0x20. A status write with bit 0 = 1 has no effect.
- R10: Bit 0 of the control register at offset 0x22 is the interrupt enable. `alarm_irq` is 1 exactly when the flag and the interrupt enable are both 1.
- R11: If a clear write and a setting tick fall in the same cycle, the flag ends up set.
- R12: Alarm value bits above a field's width (weekday 3 bits, day 6 bits, month 5 bits) are dropped and do not affect the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse once per second |
| cur_sec | input | 7 | Live BCD seconds |
| cur_min | input | 7 | Live BCD minutes |
| cur_hour | input | 7 | Live hour: BCD in bits 5:0, PM in bit 6 |
| cur_wday | input | 3 | Live weekday |
| cur_day | input | 6 | Live BCD day of month |
| cur_month | input | 5 | Live BCD month |
| cur_year | input | 8 | Live BCD year |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
Every register write and every tick takes effect at the next rising edge, and both outputs come straight from registers, so each result is due one edge after its stimulus. The driver applies one stimulus per cycle at the falling edge and queues the expected flag and interrupt for that cycle. The monitor takes the item 2 ns after the next rising edge and compares it. Field writes and ticks go in separate cycles so that each check sees one change, except in the check that places a clear and a tick in the same cycle on purpose.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
    localparam int NUM_FIELDS   = 7;
    localparam int FIELD_W      = 8;
    localparam int ADDR_W       = 6;
    localparam int YEAR_IDX     = 6;
    localparam int HOUR_IDX     = 2;
    localparam int ALARM_BASE   = 'h10;
    localparam int ALARM_STRIDE = 2;
    localparam int YEAR_EN_ADDR = 'h1E;
    localparam int STAT_ADDR    = 'h20;
    localparam int CTRL_ADDR    = 'h22;
    localparam int EN_BIT       = 7;

    typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] field_vec_t;

    // Significant bits per field: sec, min, hour(+PM), wday, day, month, year
    function automatic logic [FIELD_W-1:0] field_mask(input int idx);
        case (idx)
            0, 1, 2: field_mask = 8'h7F;
            3:       field_mask = 8'h07;
            4:       field_mask = 8'h3F;
            5:       field_mask = 8'h1F;
            default: field_mask = 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output field_vec_t        val_o,
    output logic [NUM_FIELDS-1:0] en_o,
    output logic              aie_o,
    output logic              clr_req_o
);
    typedef struct packed {
        field_vec_t            val;
        logic [NUM_FIELDS-1:0] en;
        logic                  aie;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        clr_req_o = 1'b0;
        if (wr_i) begin
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (addr_i == ADDR_W'(ALARM_BASE + ALARM_STRIDE * i)) begin
                    st_d.val[i] = wdata_i & field_mask(i);
                    if (i != YEAR_IDX) st_d.en[i] = wdata_i[EN_BIT];
                end
            end
            if (addr_i == ADDR_W'(YEAR_EN_ADDR)) st_d.en[YEAR_IDX] = wdata_i[EN_BIT];
            if (addr_i == ADDR_W'(CTRL_ADDR))    st_d.aie = wdata_i[0];
            if (addr_i == ADDR_W'(STAT_ADDR) && !wdata_i[0]) clr_req_o = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o = st_q.val;
    assign en_o  = st_q.en;
    assign aie_o = st_q.aie;

    AST_AIE_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_W'(CTRL_ADDR)) |=> (aie_o == $past(wdata_i[0]))); // R10
    AST_YEAR_EN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_W'(ALARM_BASE + ALARM_STRIDE * YEAR_IDX))
        |=> $stable(en_o[YEAR_IDX])); // R8
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_alarm_pkg::*;
(
    input  field_vec_t            alarm_i,
    input  logic [NUM_FIELDS-1:0] en_i,
    input  field_vec_t            now_i,
    output logic                  hit_o
);
    logic [NUM_FIELDS-1:0] ok;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        localparam logic [FIELD_W-1:0] MASK = field_mask(g);
        assign ok[g] = !en_i[g] || ((alarm_i[g] & MASK) == (now_i[g] & MASK));
    end

    assign hit_o = (&ok) && (|en_i);
endmodule

// File: rtl/cal_alarm_top.sv
module cal_alarm_top
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [6:0]        cur_sec,
    input  logic [6:0]        cur_min,
    input  logic [6:0]        cur_hour,
    input  logic [2:0]        cur_wday,
    input  logic [5:0]        cur_day,
    input  logic [4:0]        cur_month,
    input  logic [7:0]        cur_year,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic              alarm_flag,
    output logic              alarm_irq
);
    typedef struct packed {
        logic flag;
    } flag_st_t;

    field_vec_t            now_vec;
    field_vec_t            alarm_val;
    logic [NUM_FIELDS-1:0] alarm_en;
    logic                  aie;
    logic                  clr_req;
    logic                  hit;
    flag_st_t              fs_d, fs_q;

    assign now_vec[0] = {1'b0, cur_sec};
    assign now_vec[1] = {1'b0, cur_min};
    assign now_vec[2] = {1'b0, cur_hour};
    assign now_vec[3] = {5'b0, cur_wday};
    assign now_vec[4] = {2'b0, cur_day};
    assign now_vec[5] = {3'b0, cur_month};
    assign now_vec[6] = cur_year;

    cal_alarm_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .val_o     (alarm_val),
        .en_o      (alarm_en),
        .aie_o     (aie),
        .clr_req_o (clr_req)
    );

    cal_alarm_match u_match (
        .alarm_i (alarm_val),
        .en_i    (alarm_en),
        .now_i   (now_vec),
        .hit_o   (hit)
    );

    always_comb begin
        fs_d = fs_q;
        if (clr_req)         fs_d.flag = 1'b0;
        if (sec_tick && hit) fs_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign alarm_flag = fs_q.flag;
    assign alarm_irq  = fs_q.flag & aie;

    AST_SET_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(sec_tick)); // R3
    AST_SET_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(hit)); // R2
    AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(|alarm_en)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !clr_req) |=> alarm_flag); // R9
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && hit && clr_req) |=> alarm_flag); // R11
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (alarm_flag && aie)); // R10
endmodule

// File: tb/test_cal_alarm_top.sv
module test_cal_alarm_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [6:0] cur_sec = 7'h30;
    logic [6:0] cur_min = 7'h15;
    logic [6:0] cur_hour = 7'h47;
    logic [2:0] cur_wday = 3'd3;
    logic [5:0] cur_day = 6'h21;
    logic [4:0] cur_month = 5'h09;
    logic [7:0] cur_year = 8'h24;
    logic       reg_wr = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       alarm_flag, alarm_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic  flag;
        logic  irq;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    cal_alarm_top i_cal_alarm_top (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_wday(cur_wday), .cur_day(cur_day), .cur_month(cur_month),
        .cur_year(cur_year), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );

    // Driver: one stimulus per cycle, expectation due after the next rising edge
    task automatic cyc(input logic tk, input logic wr, input logic [5:0] a,
                       input logic [7:0] d, input logic ef, input logic ei,
                       input string tag);
        exp_t e;
        @(negedge clk);
        sec_tick  = tk;
        reg_wr    = wr;
        reg_addr  = a;
        reg_wdata = d;
        e.flag = ef; e.irq = ei; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d,
                      input logic ef, input logic ei, input string tag);
        cyc(1'b0, 1'b1, a, d, ef, ei, tag);
    endtask

    task automatic tk(input logic ef, input logic ei, input string tag);
        cyc(1'b1, 1'b0, 6'h0, 8'h0, ef, ei, tag);
    endtask

    // Monitor: compare 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_tests++;
                if (alarm_flag !== e.flag || alarm_irq !== e.irq) begin
                    n_fail++;
                    $display("FAIL %s: flag/irq = %b/%b, expected %b/%b",
                             e.tag, alarm_flag, alarm_irq, e.flag, e.irq);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run incomplete, expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc(1'b0, 1'b0, 6'h0, 8'h0, 1'b0, 1'b0, "R1 reset idle");
        tk(1'b0, 1'b0, "R1 nothing enabled after reset");
        // seconds alarm enabled at :30
        wr(6'h10, 8'hB0, 1'b0, 1'b0, "R8 sec write");
        cyc(1'b0, 1'b0, 6'h0, 8'h0, 1'b0, 1'b0, "R3 match without tick");
        tk(1'b1, 1'b0, "R2 R4 partial match sets flag");
        wr(6'h20, 8'h01, 1'b1, 1'b0, "R9 write 1 keeps flag");
        wr(6'h22, 8'h01, 1'b1, 1'b1, "R10 aie on");
        wr(6'h20, 8'h00, 1'b0, 1'b0, "R9 clear");
        // minutes enabled, mismatch
        wr(6'h12, 8'h96, 1'b0, 1'b0, "R5 min write");
        tk(1'b0, 1'b0, "R5 enabled mismatch");
        wr(6'h12, 8'h95, 1'b0, 1'b0, "R2 min write");
        tk(1'b1, 1'b1, "R2 sec+min match");
        wr(6'h20, 8'h00, 1'b0, 1'b0, "R9 clear");
        // hours PM bit
        wr(6'h14, 8'h87, 1'b0, 1'b0, "R7 hour AM write");
        tk(1'b0, 1'b0, "R7 PM bit differs");
        wr(6'h14, 8'hC7, 1'b0, 1'b0, "R7 hour PM write");
        tk(1'b1, 1'b1, "R7 PM hour match");
        wr(6'h20, 8'h00, 1'b0, 1'b0, "R9 clear");
        // year value and separate enable
        wr(6'h1C, 8'h99, 1'b0, 1'b0, "R8 year value write");
        tk(1'b1, 1'b1, "R8 year value write leaves it disabled");
        wr(6'h20, 8'h00, 1'b0, 1'b0, "R9 clear");
        wr(6'h1E, 8'h80, 1'b0, 1'b0, "R8 year enable");
        tk(1'b0, 1'b0, "R8 year enabled mismatch");
        wr(6'h1C, 8'h24, 1'b0, 1'b0, "R8 year value fix");
        tk(1'b1, 1'b1, "R8 year match");
        wr(6'h20, 8'h00, 1'b0, 1'b0, "R9 clear");
        // clear and tick in the same cycle
        cyc(1'b1, 1'b1, 6'h20, 8'h00, 1'b1, 1'b1, "R11 set wins over clear");
        wr(6'h20, 8'h00, 1'b0, 1'b0, "R9 clear");
        wr(6'h22, 8'h00, 1'b0, 1'b0, "R10 aie off");
        tk(1'b1, 1'b0, "R10 flag without irq");
        wr(6'h22, 8'h01, 1'b1, 1'b1, "R10 aie back on");
        wr(6'h20, 8'h00, 1'b0, 1'b0, "R9 clear");
        // all fields, with extra high bits on weekday
        wr(6'h16, 8'hFB, 1'b0, 1'b0, "R12 wday write");
        wr(6'h18, 8'hA1, 1'b0, 1'b0, "R8 day write");
        wr(6'h1A, 8'h89, 1'b0, 1'b0, "R8 month write");
        tk(1'b1, 1'b1, "R12 R2 full match");
        wr(6'h20, 8'h00, 1'b0, 1'b0, "R9 clear");
        // disable every field
        wr(6'h10, 8'h30, 1'b0, 1'b0, "R6 sec off");
        wr(6'h12, 8'h15, 1'b0, 1'b0, "R6 min off");
        wr(6'h14, 8'h47, 1'b0, 1'b0, "R6 hour off");
        wr(6'h16, 8'h03, 1'b0, 1'b0, "R6 wday off");
        wr(6'h18, 8'h21, 1'b0, 1'b0, "R6 day off");
        wr(6'h1A, 8'h09, 1'b0, 1'b0, "R6 month off");
        wr(6'h1E, 8'h00, 1'b0, 1'b0, "R6 year off");
        tk(1'b0, 1'b0, "R6 nothing enabled");
        cyc(1'b0, 1'b0, 6'h0, 8'h0, 1'b0, 1'b0, "R6 idle");
        @(negedge clk);
        sec_tick = 1'b0;
        reg_wr   = 1'b0;
        wait (sb_q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule